// File: doc/BRIEF.md
# MESI Coherence State Controller

This block keeps the two-bit coherence state of every line in a small snooping data cache and works out each line's next state. Each request names one line by set and way and carries one of five operations. Two come from the local processor (read, write). Two are snoops from other caches on the shared bus (read, write). The fifth is the completion of a line fill. Tag lookup is done elsewhere, so the set and way arrive already resolved.

One cycle after each request the block reports three things. It gives the state the line held before the request and the state it holds afterwards. It also gives the bus cycle the bus interface must run: none, a line fill, a write-through or a write-back. The new state is written at the same clock edge, so the next request in the following cycle sees it. A parameter selects a read-only instruction-cache variant. That variant stores one bit per line and only ever holds Shared or Invalid.

The transition table, by operation: a processor read keeps the state. A processor write promotes Exclusive to Modified. A write-through keeps Shared and Invalid as they are. A snoop read demotes to Shared. A snoop write invalidates. A fill completion installs the line as Exclusive or Shared.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. State codes are Modified=3, Exclusive=2, Shared=1, Invalid=0, and resp_prev reports the state before the request.
- R2: A processor read (op 0) never changes the state. It returns bus cycle code 1 (line fill) when the line is Invalid and code 0 (none) otherwise.
- R3: A processor write (op 1) to a Modified or Exclusive line leaves the line Modified with bus cycle 0.
- R4: A processor write to a Shared line keeps it Shared and returns bus cycle 2 (write-through). A processor write to an Invalid line keeps it Invalid and also returns bus cycle 2.
- R5: A snoop read (op 2) moves Modified to Shared with bus cycle 3 (write-back) and moves Exclusive to Shared with bus cycle 0. It leaves Shared and Invalid unchanged with bus cycle 0.
- R6: A snoop write (op 3) moves every line to Invalid. The bus cycle is 3 when the line was Modified and 0 otherwise.
- R7: A fill completion (op 4) installs the line as Exclusive when fill_shared is 0 and as Shared when it is 1, with bus cycle 0.
- R8: resp_valid is high exactly one cycle after each accepted request. A request in the very next cycle to the same line sees the updated state.
- R9: Operation codes 5 to 7 leave the state unchanged with bus cycle 0.
- R10: With CODE_ONLY=1 a line only holds Shared or Invalid. A fill always installs Shared, and a processor write changes nothing and returns bus cycle 0.
- R11: A request changes only the line selected by its set and way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 read, 1 write, 2 snoop read, 3 snoop write, 4 fill done) |
| req_set | input | SETW | Set index |
| req_way | input | WAYW | Way index |
| fill_shared | input | 1 | For fill completion: another cache also holds the line |
| resp_valid | output | 1 | Response present |
| resp_prev | output | 2 | State before the request |
| resp_next | output | 2 | State after the request |
| resp_cycle | output | 2 | Bus cycle to issue |

## Verification
The hardest case to reach from the ports is the Modified state. No operation enters it directly: the line must first be filled as Exclusive, with fill_shared low, and then written by the processor. The bench builds each of the four start states with such a short preparation sequence. A snoop write first clears the line; a Shared or Exclusive fill follows, then a write for Modified. Each operation code is then applied, and a processor read issued in the very next cycle checks that the new state was stored.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CY_NONE  = 2'd0,
        CY_FILL  = 2'd1,
        CY_WTHRU = 2'd2,
        CY_WBACK = 2'd3
    } bus_cy_t;

    typedef enum logic [2:0] {
        OP_PRD  = 3'd0,
        OP_PWR  = 3'd1,
        OP_SRD  = 3'd2,
        OP_SWR  = 3'd3,
        OP_FILL = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } line_op_t;
endpackage

// File: rtl/mesi_state_store.sv
module mesi_state_store
    import mesi_pkg::*;
#(
    parameter int IDXW = 5,
    parameter int SW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rd_idx,
    output line_st_t        rd_state,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [SW-1:0]   wr_bits
);
    localparam int LINES = 1 << IDXW;

    logic [SW-1:0] lines_q [LINES];
    logic [SW-1:0] raw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) lines_q[i] <= '0;
        end else if (wr_en) begin
            lines_q[wr_idx] <= wr_bits;
        end
    end

    assign raw = lines_q[rd_idx];

    generate
        if (SW == 1) begin : g_one_bit
            assign rd_state = line_st_t'({1'b0, raw});
        end else begin : g_two_bit
            assign rd_state = line_st_t'(raw);
        end
    endgenerate
endmodule

// File: rtl/mesi_next.sv
module mesi_next
    import mesi_pkg::*;
#(
    parameter bit CODE_ONLY = 1'b0
) (
    input  line_op_t op,
    input  line_st_t cur,
    input  logic     shared,
    output line_st_t nxt,
    output bus_cy_t  cyc
);
    always_comb begin
        nxt = cur;
        cyc = CY_NONE;
        unique case (op)
            OP_PRD: begin
                if (cur == ST_I) cyc = CY_FILL;
            end
            OP_PWR: begin
                if (!CODE_ONLY) begin
                    unique case (cur)
                        ST_M, ST_E: nxt = ST_M;
                        ST_S, ST_I: cyc = CY_WTHRU;
                        default: ;
                    endcase
                end
            end
            OP_SRD: begin
                if (cur == ST_M) begin
                    nxt = ST_S;
                    cyc = CY_WBACK;
                end else if (cur == ST_E) begin
                    nxt = ST_S;
                end
            end
            OP_SWR: begin
                nxt = ST_I;
                if (cur == ST_M) cyc = CY_WBACK;
            end
            OP_FILL: begin
                nxt = (CODE_ONLY || shared) ? ST_S : ST_E;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int SETS      = 16,
    parameter int WAYS      = 2,
    parameter bit CODE_ONLY = 1'b0,
    localparam int SETW     = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAYW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [SETW-1:0] req_set,
    input  logic [WAYW-1:0] req_way,
    input  logic            fill_shared,
    output logic            resp_valid,
    output logic [1:0]      resp_prev,
    output logic [1:0]      resp_next,
    output logic [1:0]      resp_cycle
);
    localparam int IDXW = SETW + WAYW;
    localparam int SW   = CODE_ONLY ? 1 : 2;

    logic [IDXW-1:0] idx;
    line_st_t        cur_st, nxt_st;
    bus_cy_t         cyc;
    line_op_t        op;

    line_st_t prev_q, next_q;
    bus_cy_t  cyc_q;
    line_op_t op_q;
    logic     valid_q;

    assign idx = {req_set, req_way};
    assign op  = line_op_t'(req_op);

    mesi_state_store #(.IDXW(IDXW), .SW(SW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_state (cur_st),
        .wr_en    (req_valid),
        .wr_idx   (idx),
        .wr_bits  (nxt_st[SW-1:0])
    );

    mesi_next #(.CODE_ONLY(CODE_ONLY)) u_next (
        .op     (op),
        .cur    (cur_st),
        .shared (fill_shared),
        .nxt    (nxt_st),
        .cyc    (cyc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            prev_q  <= ST_I;
            next_q  <= ST_I;
            cyc_q   <= CY_NONE;
            op_q    <= OP_PRD;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                prev_q <= cur_st;
                next_q <= nxt_st;
                cyc_q  <= cyc;
                op_q   <= op;
            end
        end
    end

    assign resp_valid = valid_q;
    assign resp_prev  = prev_q;
    assign resp_next  = next_q;
    assign resp_cycle = cyc_q;

    // R8: one response per request, one cycle later
    p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R2: line fill only for a processor read that missed
    p_fill_on_read_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && cyc_q == CY_FILL) |-> (op_q == OP_PRD && prev_q == ST_I));

    // R2: processor read keeps the state
    p_read_keeps_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && op_q == OP_PRD) |-> (next_q == prev_q));

    // R3: Modified is only entered by a write or kept
    p_enter_modified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && next_q == ST_M) |-> (prev_q == ST_M || prev_q == ST_E));

    // R6: write-back only from a Modified line
    p_wback_from_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && cyc_q == CY_WBACK) |-> (prev_q == ST_M));

    // R9: reserved codes do nothing
    p_reserved_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && op_q > OP_FILL) |-> (next_q == prev_q && cyc_q == CY_NONE));

    generate
        if (CODE_ONLY) begin : g_code_chk
            // R10: read-only variant holds only Shared or Invalid
            p_code_si_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
                resp_valid |-> (next_q == ST_S || next_q == ST_I));
        end
    endgenerate
endmodule

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
    localparam int SETS = 16;
    localparam int WAYS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v0 = 1'b0, v1 = 1'b0;
    logic [2:0] op = '0;
    logic [3:0] set_i = '0;
    logic       way_i = 1'b0;
    logic       sh = 1'b0;
    logic       rv0, rv1;
    logic [1:0] pv0, nx0, cy0, pv1, nx1, cy1;

    int checks = 0;
    int errors = 0;
    logic [1:0] got_prev, got_next, got_cyc;
    logic       got_valid;

    always #4 clk = ~clk;

    mesi_line_ctrl #(.SETS(SETS), .WAYS(WAYS), .CODE_ONLY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_op(op),
        .req_set(set_i), .req_way(way_i), .fill_shared(sh),
        .resp_valid(rv0), .resp_prev(pv0), .resp_next(nx0), .resp_cycle(cy0));

    mesi_line_ctrl #(.SETS(SETS), .WAYS(WAYS), .CODE_ONLY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_op(op),
        .req_set(set_i), .req_way(way_i), .fill_shared(sh),
        .resp_valid(rv1), .resp_prev(pv1), .resp_next(nx1), .resp_cycle(cy1));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one request at a falling edge; results are captured one cycle later.
    task automatic do_op(input bit code, input int o, input int s, input int w, input bit f);
        op = 3'(o); set_i = 4'(s); way_i = w[0]; sh = f;
        v0 = !code; v1 = code;
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
        got_valid = code ? rv1 : rv0;
        got_prev  = code ? pv1 : pv0;
        got_next  = code ? nx1 : nx0;
        got_cyc   = code ? cy1 : cy0;
    endtask

    // Expected transition from the requirement table (data variant)
    task automatic expect_step(input int o, input int st, input bit f, output int nx, output int cy);
        nx = st; cy = 0;
        case (o)
            0: cy = (st == 0) ? 1 : 0;
            1: begin if (st >= 2) nx = 3; else cy = 2; end
            2: begin if (st == 3) begin nx = 1; cy = 3; end else if (st == 2) nx = 1; end
            3: begin nx = 0; cy = (st == 3) ? 3 : 0; end
            4: nx = f ? 1 : 2;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int o, input int st);
        case (o)
            0: return "R2";
            1: return (st >= 2) ? "R3" : "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic prepare(input int s, input int w, input int st);
        do_op(0, 3, s, w, 1'b0);
        if (st == 1) do_op(0, 4, s, w, 1'b1);
        if (st >= 2) do_op(0, 4, s, w, 1'b0);
        if (st == 3) do_op(0, 1, s, w, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int enx, ecy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle resp_valid", int'(rv0), 0);

        // R1: every line starts Invalid; a read reports a fill
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                do_op(0, 0, s, w, 1'b0);
                chk("R1 reset prev", int'(got_prev), 0);
                chk("R2 reset read fill", int'(got_cyc), 1);
            end
        end
        @(negedge clk);
        chk("R8 resp_valid drops", int'(rv0), 0);

        // R11: only the addressed line changes
        prepare(3, 0, 3);
        do_op(0, 0, 3, 1, 1'b0);
        chk("R11 other way", int'(got_prev), 0);
        do_op(0, 0, 4, 0, 1'b0);
        chk("R11 other set", int'(got_prev), 0);
        do_op(0, 0, 3, 0, 1'b0);
        chk("R11 target line", int'(got_prev), 3);

        // Sweep: every start state x every op code x fill_shared
        for (int st = 0; st < 4; st++) begin
            for (int o = 0; o < 8; o++) begin
                for (int f = 0; f < 2; f++) begin
                    int s = (o * 2 + f) % SETS;
                    int w = st % WAYS;
                    prepare(s, w, st);
                    expect_step(o, st, f[0], enx, ecy);
                    do_op(0, o, s, w, f[0]);
                    chk({tag_of(o, st), " valid"}, int'(got_valid), 1);
                    chk({tag_of(o, st), " prev"}, int'(got_prev), st);
                    chk({tag_of(o, st), " next"}, int'(got_next), enx);
                    chk({tag_of(o, st), " cycle"}, int'(got_cyc), ecy);
                    do_op(0, 0, s, w, 1'b0);
                    chk("R8 back-to-back stored", int'(got_prev), enx);
                end
            end
        end

        // R10: read-only variant
        do_op(1, 0, 5, 1, 1'b0);
        chk("R10 reset prev", int'(got_prev), 0);
        chk("R10 read miss fill", int'(got_cyc), 1);
        do_op(1, 4, 5, 1, 1'b0);
        chk("R10 fill installs Shared", int'(got_next), 1);
        do_op(1, 1, 5, 1, 1'b0);
        chk("R10 write prev", int'(got_prev), 1);
        chk("R10 write next", int'(got_next), 1);
        chk("R10 write cycle", int'(got_cyc), 0);
        do_op(1, 2, 5, 1, 1'b0);
        chk("R10 snoop read keeps", int'(got_next), 1);
        do_op(1, 0, 5, 1, 1'b0);
        chk("R10 read hit", int'(got_cyc), 0);
        do_op(1, 3, 5, 1, 1'b0);
        chk("R10 snoop write", int'(got_next), 0);
        chk("R10 snoop write cycle", int'(got_cyc), 0);
        do_op(1, 1, 5, 1, 1'b0);
        chk("R10 write on Invalid", int'(got_cyc), 0);
        chk("R10 write on Invalid next", int'(got_next), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule